// File: doc/BRIEF.md
# Shared Under-Load Delay Timer

This block qualifies under-current indications from a bank of switch channels and judges them with one delay counter that all channels share, instead of a counter for each channel. A channel's under-current flag counts only while that switch is commanded on and has not already been forced off. The first qualifying channel starts the shared counter. Any channel that qualifies later inherits whatever time is left on that counter. The counter advances on a slow time-base tick, typically one per millisecond. Its length in ticks is a parameter, with a default near 350.

When the counter expires, a sticky under-load status bit is raised. If the shutdown-enable control is set at that moment, every channel still qualifying is latched off. If it is clear, the channels keep the state they were commanded to. Only a status-reset strobe or the enable input going low clears the status bit, the latches and the counter. The block has no data stream: every pin is a plain level or strobe sampled on the clock. The outputs are registered and do not depend combinationally on the inputs.

Top module: `uld_shared_timer`

## Requirements
- R1: After reset, `trip_off` is all zero and `uld_flag` is 0.
- R2: A channel qualifies only while `under_cur[i]`, `sw_on[i]` and not `trip_off[i]` all hold. An under-current flag on a switch that is off never advances the counter or sets `uld_flag`.
- R3: The counter starts from zero on the first cycle any channel qualifies. It advances once per cycle in which `tick` is 1 and some channel qualifies. It expires on the DELAY_TICKS-th such tick.
- R4: A channel that starts qualifying while the counter runs does not restart the counter. It takes part in the expiry of the running count.
- R5: In any cycle with no qualifying channel, the counter returns to zero.
- R6: Expiry sets `uld_flag` on the following clock edge, and the flag then stays at 1.
- R7: At expiry, the channels qualifying in that cycle get `trip_off` set only if `shutdown_en` is 1 in that cycle. With `shutdown_en` at 0, `trip_off` is unchanged.
- R8: A set `trip_off[i]` stays set whatever `sw_on`, `under_cur` or `shutdown_en` do, until it is cleared.
- R9: A cycle with `status_rst` at 1 clears `uld_flag`, every `trip_off` bit and the counter. A condition still present afterwards needs a full DELAY_TICKS again.
- R10: A cycle with `enable` at 0 clears the same state as R9 and keeps it cleared.
- R11: At expiry the counter returns to zero. While a channel keeps qualifying, it counts another full period and expires again, latching any channel that qualifies then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Device enable; low clears all state |
| tick | input | 1 | Time-base strobe, one cycle wide |
| status_rst | input | 1 | Status-reset strobe |
| shutdown_en | input | 1 | Latch off channels at expiry when 1 |
| sw_on | input | NUM_CH | Commanded on state for each switch |
| under_cur | input | NUM_CH | Under-current flag for each switch |
| trip_off | output | NUM_CH | Channel forced off by under-load |
| uld_flag | output | 1 | Sticky under-load status |

## Verification
The assertions assume that `tick`, `status_rst` and `enable` are synchronous to `clk`. They also assume that `status_rst` is a pulse and not a level held through the delay window. The stimulus drives every input on the falling clock edge. It issues status resets as single-cycle strobes and varies the tick spacing, including back-to-back ticks and long gaps. It also staggers channel arrivals so that later channels land mid-count and inherit the time left on the running counter.

// File: rtl/uld_pkg.sv
package uld_pkg;
  localparam int unsigned DEF_NUM_CH      = 12;
  localparam int unsigned DEF_DELAY_TICKS = 350;

  typedef enum logic [1:0] {
    TMR_IDLE   = 2'd0,
    TMR_COUNT  = 2'd1,
    TMR_EXPIRE = 2'd2
  } tmr_event_e;
endpackage

// File: rtl/uld_qualify.sv
module uld_qualify #(
  parameter int unsigned NUM_CH = 12
) (
  input  logic [NUM_CH-1:0] sw_on,
  input  logic [NUM_CH-1:0] under_cur,
  input  logic [NUM_CH-1:0] tripped,
  output logic [NUM_CH-1:0] qual,
  output logic              any_qual
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign qual[g] = under_cur[g] & sw_on[g] & ~tripped[g];
  end
  assign any_qual = |qual;
endmodule

// File: rtl/uld_delay_timer.sv
module uld_delay_timer
  import uld_pkg::*;
#(
  parameter int unsigned DELAY_TICKS = 350
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic any_qual,
  input  logic tick,
  output logic expire
);
  localparam int unsigned CNT_W = (DELAY_TICKS < 2) ? 1 : $clog2(DELAY_TICKS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  tmr_event_e       evt;

  always_comb begin
    if (clear || !any_qual)        evt = TMR_IDLE;
    else if (tick && cnt_q == LAST) evt = TMR_EXPIRE;
    else                            evt = TMR_COUNT;
  end

  assign expire = (evt == TMR_EXPIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else begin
      unique case (evt)
        TMR_IDLE, TMR_EXPIRE: cnt_q <= '0;
        TMR_COUNT:            if (tick) cnt_q <= cnt_q + 1'b1;
        default:              cnt_q <= '0;
      endcase
    end
  end
endmodule

// File: rtl/uld_latch_bank.sv
module uld_latch_bank #(
  parameter int unsigned NUM_CH = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              expire,
  input  logic              shutdown_en,
  input  logic [NUM_CH-1:0] qual,
  output logic [NUM_CH-1:0] tripped,
  output logic              flag
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_lat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  tripped[g] <= 1'b0;
      else if (clear)                              tripped[g] <= 1'b0;
      else if (expire && shutdown_en && qual[g])   tripped[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (clear)  flag <= 1'b0;
    else if (expire) flag <= 1'b1;
  end
endmodule

// File: rtl/uld_shared_timer.sv
module uld_shared_timer
  import uld_pkg::*;
#(
  parameter int unsigned NUM_CH      = DEF_NUM_CH,
  parameter int unsigned DELAY_TICKS = DEF_DELAY_TICKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  logic              status_rst,
  input  logic              shutdown_en,
  input  logic [NUM_CH-1:0] sw_on,
  input  logic [NUM_CH-1:0] under_cur,
  output logic [NUM_CH-1:0] trip_off,
  output logic              uld_flag
);
  logic [NUM_CH-1:0] qual;
  logic              any_qual;
  logic              expire;
  logic              clear;

  assign clear = status_rst | ~enable;

  uld_qualify #(.NUM_CH(NUM_CH)) u_qual (
    .sw_on(sw_on), .under_cur(under_cur), .tripped(trip_off),
    .qual(qual), .any_qual(any_qual)
  );

  uld_delay_timer #(.DELAY_TICKS(DELAY_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clear(clear), .any_qual(any_qual),
    .tick(tick), .expire(expire)
  );

  uld_latch_bank #(.NUM_CH(NUM_CH)) u_lat (
    .clk(clk), .rst_n(rst_n), .clear(clear), .expire(expire),
    .shutdown_en(shutdown_en), .qual(qual), .tripped(trip_off),
    .flag(uld_flag)
  );
endmodule

// File: rtl/uld_shared_timer_chk.sv
module uld_shared_timer_chk #(
  parameter int unsigned NUM_CH = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              tick,
  input logic              status_rst,
  input logic              shutdown_en,
  input logic [NUM_CH-1:0] sw_on,
  input logic [NUM_CH-1:0] under_cur,
  input logic [NUM_CH-1:0] trip_off,
  input logic              uld_flag
);
  // R7
  new_trip_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((trip_off & ~$past(trip_off)) != '0) |-> ($past(shutdown_en) && uld_flag));

  // R2
  trip_only_loaded_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((trip_off & ~$past(trip_off) & ~($past(under_cur) & $past(sw_on))) == '0));

  // R9
  clear_empties_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rst || !enable) |=> (trip_off == '0 && !uld_flag));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uld_flag && enable && !status_rst) |=> uld_flag);

  // R8
  trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !status_rst) |=> ((trip_off & $past(trip_off)) == $past(trip_off)));

  // R3
  flag_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uld_flag) |-> $past(tick));
endmodule

bind uld_shared_timer uld_shared_timer_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
  .status_rst(status_rst), .shutdown_en(shutdown_en), .sw_on(sw_on),
  .under_cur(under_cur), .trip_off(trip_off), .uld_flag(uld_flag)
);

// File: tb/test_uld_shared_timer.sv
`timescale 1ns/1ps
module test_uld_shared_timer;
  localparam int N = 12;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1, tick = 1'b0, status_rst = 1'b0, shutdown_en = 1'b0;
  logic [N-1:0] sw_on = '0, under_cur = '0;
  logic [N-1:0] trip_off;
  logic uld_flag;

  int n_vec = 0, n_bad = 0;

  always #4 clk = ~clk;

  uld_shared_timer #(.NUM_CH(N), .DELAY_TICKS(D)) i_uld_shared_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .status_rst(status_rst), .shutdown_en(shutdown_en), .sw_on(sw_on),
    .under_cur(under_cur), .trip_off(trip_off), .uld_flag(uld_flag)
  );

  // behavioural reference
  int       m_ticks;
  bit [N-1:0] m_trip;
  bit       m_flag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ticks = 0; m_trip = '0; m_flag = 0;
    end else if (status_rst || !enable) begin
      m_ticks = 0; m_trip = '0; m_flag = 0;
    end else begin
      bit [N-1:0] loaded;
      loaded = '0;
      for (int i = 0; i < N; i++)
        loaded[i] = under_cur[i] && sw_on[i] && !m_trip[i];
      if (loaded == '0) m_ticks = 0;
      else if (tick) begin
        m_ticks = m_ticks + 1;
        if (m_ticks == D) begin
          m_ticks = 0;
          m_flag = 1;
          if (shutdown_en) m_trip = m_trip | loaded;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // model comparison on every clock
  always @(negedge clk) if (rst_n) begin
    chk(uld_flag == m_flag, "R6 model", uld_flag, m_flag);
    chk(trip_off == m_trip, "R7 model", trip_off, m_trip);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rst();
    status_rst = 1; cyc(1); status_rst = 0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    cyc(2); rst_n = 1; cyc(1);
    chk(trip_off == '0 && !uld_flag, "R1", {trip_off, uld_flag}, 0);

    // R2: under-current on switched-off channel never counts
    tick = 1; shutdown_en = 1; under_cur = 12'h001; cyc(10);
    chk(!uld_flag, "R2", uld_flag, 0);

    // R3: exact expiry on D-th tick
    sw_on = 12'h001; cyc(D-1);
    chk(!uld_flag, "R3 early", uld_flag, 0);
    cyc(1);
    chk(uld_flag && trip_off == 12'h001, "R3", trip_off, 12'h001);
    // R8: latched despite switch off
    sw_on = '0; under_cur = '0; cyc(3);
    chk(trip_off == 12'h001, "R8", trip_off, 12'h001);

    // R9: clear then full period again
    sw_on = 12'h001; under_cur = 12'h001; pulse_rst();
    chk(trip_off == '0 && !uld_flag, "R9 clear", trip_off, 0);
    cyc(D-1);
    chk(!uld_flag, "R9 restart", uld_flag, 0);
    cyc(1);
    chk(uld_flag, "R9 expire", uld_flag, 1);

    // R4: late channel inherits remaining time
    sw_on = '0; under_cur = '0; pulse_rst();
    sw_on = 12'h006; under_cur = 12'h002; cyc(2);
    under_cur = 12'h006; cyc(D-2);
    chk(trip_off == 12'h006, "R4", trip_off, 12'h006);

    // R5: gap returns counter to zero
    sw_on = 12'h008; under_cur = 12'h000; pulse_rst();
    under_cur = 12'h008; cyc(D-1); under_cur = '0; cyc(1);
    under_cur = 12'h008; cyc(D-1);
    chk(!uld_flag, "R5", uld_flag, 0);
    cyc(1);
    chk(uld_flag && trip_off == 12'h008, "R5 expire", trip_off, 12'h008);

    // R7 / R11: shutdown off, repeated expiry, then enable shutdown
    pulse_rst(); shutdown_en = 0; sw_on = 12'h030; under_cur = 12'h030;
    cyc(D);
    chk(uld_flag && trip_off == '0, "R7 no latch", trip_off, 0);
    shutdown_en = 1; cyc(D-1);
    chk(trip_off == '0, "R11 early", trip_off, 0);
    cyc(1);
    chk(trip_off == 12'h030, "R11", trip_off, 12'h030);

    // R10: enable low clears and holds
    enable = 0; cyc(D+2);
    chk(trip_off == '0 && !uld_flag, "R10", trip_off, 0);
    enable = 1;

    // sparse ticks, mixed patterns
    for (int k = 0; k < 3000; k++) begin
      tick        = ($urandom_range(0, 2) == 0);
      sw_on       = N'($urandom);
      under_cur   = ($urandom_range(0, 3) == 0) ? N'($urandom) : under_cur;
      shutdown_en = ($urandom_range(0, 4) != 0);
      status_rst  = ($urandom_range(0, 60) == 0);
      enable      = ($urandom_range(0, 200) != 0);
      cyc(1);
    end
    status_rst = 0; enable = 1; cyc(2);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule